// File: doc/BRIEF.md
# AUX Request Framing and Status Controller

This controller sits between a host command port and the command FIFO of a display auxiliary channel. The host hands it one request: native or I2C-over-AUX, read or write, a 20-bit target address, a byte length, and (for writes) payload bytes that the block fetches by index. The block first checks the length limits and answers zero-length requests on its own. For any other request it pushes a four-byte header, plus the payload on writes, into the FIFO and raises a one-cycle start command. It then waits for completion flags from the channel.

When flags arrive, the block turns them into an error code. The mapping uses a fixed priority that is different for native and I2C requests. The block replies ACK when the code is zero and DEFER otherwise, so the host knows to retry. A completion timer closes a transaction that never receives flags. A counter of consecutive native failures raises a reconfigure pulse on every fifth failure.

The controller is a five-state machine:
- IDLE accepts a request. It moves to PUSH for a legal non-empty request, or straight to RESP for an empty or rejected one.
- PUSH sends one FIFO byte per cycle and moves to START after the last byte.
- START issues the start pulse for one cycle and moves to WAIT.
- WAIT holds until a flag arrives or the timer expires, then moves to RESP.
- RESP presents the reply until the host accepts it, then returns to IDLE.

Top module: `aux_req_ctrl`

## Requirements
- R1: The FIFO bytes begin with a four-byte header:
  - byte 0 is `{3'b000, read, addr[19:16]}`;
  - byte 1 is `addr[15:8]`;
  - byte 2 is `addr[7:0]`;
  - byte 3 is the length minus one.
  `fifo_first` is high on byte 0 only.
- R2: A read pushes exactly the 4 header bytes. A write pushes the header and then `len` payload bytes, in the order `pay_idx` = 0, 1, …, one byte per cycle.
- R3: The block rejects a request if any of these holds: it is native with length above 16, its length is above 128, or it is a write whose FIFO byte count (len+4) exceeds 128. A rejected request is answered with `rsp_kind`=2 (REJECT) and `rsp_err`=0. It pushes no FIFO byte and issues no start.
- R4: A zero-length request is answered with `rsp_kind`=0 (ACK) and `rsp_err`=0. It pushes no byte and issues no start. `rsp_i2c` equals the inverse of `req_native`.
- R5: `go_valid` is a one-cycle pulse in the cycle after the last FIFO byte.
  - Native requests: `go_i2c`, `go_no_addr` and `go_no_stop` are all low.
  - I2C reads: `go_i2c` and `go_no_addr` are high.
  - I2C writes: `go_i2c`, `go_no_addr` and `go_no_stop` are all high.
- R6: Native error mapping. The flag bits are: `st_flags[0]` done, `[1]` wrong address, `[2]` timeout, `[3]` nack/defer, `[4]` line error, `[5]` I2C nack, `[6]` I2C defer. The error codes are: 0 none, 1 address, 2 timeout, 3 nack, 4 defer, 5 nack-defer, 6 line error.
  - The base code is none if done is set. Otherwise it is address if wrong address is set. Otherwise it is timeout if timeout is set. Otherwise it is none.
  - Nack/defer then forces nack.
  - Line error then forces code 6.
- R7: I2C error mapping.
  - With done set, the result is nack (3) if either I2C nack or I2C defer is set, and none otherwise.
  - Without done, the base is address if wrong address is set, else timeout if timeout is set, else none.
  - The following flags then override the base in this order, each later one winning: nack/defer (5), I2C nack (3), I2C defer (4), line error (6).
- R8: A reply with `rsp_err`=0 has `rsp_kind`=0 (ACK). A reply with a non-zero code has `rsp_kind`=1 (DEFER).
- R9: If no flag arrives, the reply appears TMO_CYC+1 cycles after the start cycle, with `rsp_err`=2.
- R10: Flags present while the block is not waiting for completion are ignored. They produce no reply and leave the block idle.
- R11: `reconfig` pulses for one cycle together with the reply of every fifth consecutive failed native transaction. Any transaction that ends without error clears the count. Failed I2C transactions, rejects and empty requests leave the count unchanged.
- R12: `req_ready` is high only when idle. `busy` stays high from acceptance until the reply is taken. While `rsp_ready` is low, the reply and its fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_native | input | 1 | 1 = native request, 0 = I2C-over-AUX |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Data length in bytes |
| pay_idx | output | LEN_W | Index of the payload byte being fetched |
| pay_byte | input | 8 | Payload byte at pay_idx |
| fifo_valid | output | 1 | FIFO byte strobe |
| fifo_first | output | 1 | Marks the first byte of a frame |
| fifo_byte | output | 8 | FIFO byte |
| go_valid | output | 1 | Start-transaction pulse |
| go_i2c | output | 1 | Start command: I2C transaction |
| go_no_addr | output | 1 | Start command: suppress address phase |
| go_no_stop | output | 1 | Start command: suppress stop |
| st_flags | input | 7 | Completion status flags |
| rsp_valid | output | 1 | Reply available |
| rsp_ready | input | 1 | Host takes the reply |
| rsp_kind | output | 2 | 0 ACK, 1 DEFER, 2 REJECT |
| rsp_i2c | output | 1 | Reply belongs to an I2C request |
| rsp_err | output | 3 | Error code |
| busy | output | 1 | Request in progress |
| reconfig | output | 1 | Channel reconfigure pulse |

## Verification
The cycle at which each result is due can be counted from the acceptance edge:
- Empty and rejected requests are answered in the cycle right after acceptance.
- FIFO bytes follow one per cycle from that same cycle.
- The start pulse follows the last byte by one cycle.
- The reply follows a flagged WAIT cycle by one cycle, or arrives TMO_CYC+1 cycles after the start when no flag comes.

The bench drives every input on the falling edge and samples on the falling edge, stepping exactly these counts. It checks the reply at the precise cycle and checks `reconfig` one cycle later, once the pulse has come and gone. A sweep over all 127 non-zero flag patterns for both request types compares the codes against an arithmetic model of the priority rules.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_START,
        ST_WAIT,
        ST_RESP
    } ctrl_state_t;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_ADDR       = 3'd1,
        ERR_TOUT       = 3'd2,
        ERR_NACK       = 3'd3,
        ERR_DEFER      = 3'd4,
        ERR_NACK_DEFER = 3'd5,
        ERR_LINE       = 3'd6
    } err_code_t;

    typedef enum logic [1:0] {
        RSP_ACK    = 2'd0,
        RSP_DEFER  = 2'd1,
        RSP_REJECT = 2'd2
    } rsp_kind_t;

    localparam int FLAG_W   = 7;
    localparam int FL_DONE  = 0;
    localparam int FL_WADDR = 1;
    localparam int FL_TOUT  = 2;
    localparam int FL_NDEF  = 3;
    localparam int FL_LINE  = 4;
    localparam int FL_INACK = 5;
    localparam int FL_IDEF  = 6;

endpackage

// File: rtl/aux_hdr_pack.sv
module aux_hdr_pack #(
    parameter int LEN_W = 8,
    parameter int IDX_W = LEN_W + 1
) (
    input  logic             rd,
    input  logic [19:0]      addr,
    input  logic [LEN_W-1:0] len,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       pay_byte,
    output logic [7:0]       byte_out,
    output logic [LEN_W-1:0] pay_idx
);

    localparam logic [IDX_W-1:0] HDR_BYTES = IDX_W'(4);

    logic [LEN_W-1:0] len_m1;

    always_comb begin
        len_m1  = len - LEN_W'(1);
        pay_idx = (idx >= HDR_BYTES) ? LEN_W'(idx - HDR_BYTES) : '0;
        unique case (idx)
            IDX_W'(0): byte_out = {3'b000, rd, addr[19:16]};
            IDX_W'(1): byte_out = addr[15:8];
            IDX_W'(2): byte_out = addr[7:0];
            IDX_W'(3): byte_out = 8'(len_m1);
            default:   byte_out = pay_byte;
        endcase
    end

endmodule

// File: rtl/aux_status_map.sv
module aux_status_map
    import aux_req_pkg::*;
(
    input  logic              native,
    input  logic [FLAG_W-1:0] flags,
    output err_code_t         err
);

    always_comb begin
        err = ERR_NONE;
        if (native) begin
            if (flags[FL_DONE])       err = ERR_NONE;
            else if (flags[FL_WADDR]) err = ERR_ADDR;
            else if (flags[FL_TOUT])  err = ERR_TOUT;
            if (flags[FL_NDEF])       err = ERR_NACK;
            if (flags[FL_LINE])       err = ERR_LINE;
        end else if (flags[FL_DONE]) begin
            err = (flags[FL_INACK] || flags[FL_IDEF]) ? ERR_NACK : ERR_NONE;
        end else begin
            if (flags[FL_WADDR])      err = ERR_ADDR;
            else if (flags[FL_TOUT])  err = ERR_TOUT;
            if (flags[FL_NDEF])       err = ERR_NACK_DEFER;
            if (flags[FL_INACK])      err = ERR_NACK;
            if (flags[FL_IDEF])       err = ERR_DEFER;
            if (flags[FL_LINE])       err = ERR_LINE;
        end
    end

endmodule

// File: rtl/aux_fail_count.sv
module aux_fail_count #(
    parameter int RETRY_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic native,
    input  logic fail,
    output logic pulse
);

    localparam int CNT_W = (RETRY_DIV > 2) ? $clog2(RETRY_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (upd) begin
                if (!fail) begin
                    cnt <= '0;
                end else if (native) begin
                    if (cnt == CNT_LAST) begin
                        cnt   <= '0;
                        pulse <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/aux_req_ctrl.sv
module aux_req_ctrl
    import aux_req_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int NATIVE_MAX = 16,
    parameter int XFER_MAX   = 128,
    parameter int FIFO_LIM   = 128,
    parameter int RETRY_DIV  = 5,
    parameter int TMO_CYC    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_native,
    input  logic             req_read,
    input  logic [19:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic [LEN_W-1:0] pay_idx,
    input  logic [7:0]       pay_byte,
    output logic             fifo_valid,
    output logic             fifo_first,
    output logic [7:0]       fifo_byte,
    output logic             go_valid,
    output logic             go_i2c,
    output logic             go_no_addr,
    output logic             go_no_stop,
    input  logic [6:0]       st_flags,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [1:0]       rsp_kind,
    output logic             rsp_i2c,
    output logic [2:0]       rsp_err,
    output logic             busy,
    output logic             reconfig
);

    localparam int IDX_W = LEN_W + 1;
    localparam int TMO_W = $clog2(TMO_CYC);
    localparam logic [IDX_W-1:0] NAT_LIM  = IDX_W'(NATIVE_MAX);
    localparam logic [IDX_W-1:0] XFER_LIM = IDX_W'(XFER_MAX);
    localparam logic [IDX_W-1:0] FIFO_CAP = IDX_W'(FIFO_LIM);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);

    ctrl_state_t      state, state_nx;
    logic             r_native, r_read;
    logic [19:0]      r_addr;
    logic [LEN_W-1:0] r_len;
    logic [IDX_W-1:0] idx, r_last;
    logic [TMO_W-1:0] timer;
    rsp_kind_t        kind_q;
    err_code_t        err_q, map_err;

    logic [IDX_W-1:0] len_x;
    logic             req_fire, req_zero, req_rej;
    logic             flags_any, tmo_hit, wait_end;

    always_comb begin
        len_x     = IDX_W'(req_len);
        req_fire  = req_valid && (state == ST_IDLE);
        req_zero  = (req_len == '0);
        req_rej   = (req_native && (len_x > NAT_LIM)) || (len_x > XFER_LIM) ||
                    (!req_read && ((len_x + IDX_W'(4)) > FIFO_CAP));
        flags_any = |st_flags;
        tmo_hit   = (timer == TMO_LAST);
        wait_end  = (state == ST_WAIT) && (flags_any || tmo_hit);
    end

    aux_hdr_pack #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_pack (
        .rd       (r_read),
        .addr     (r_addr),
        .len      (r_len),
        .idx      (idx),
        .pay_byte (pay_byte),
        .byte_out (fifo_byte),
        .pay_idx  (pay_idx)
    );

    aux_status_map u_map (
        .native (r_native),
        .flags  (st_flags),
        .err    (map_err)
    );

    aux_fail_count #(.RETRY_DIV(RETRY_DIV)) u_fail (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (wait_end),
        .native (r_native),
        .fail   (!flags_any || (map_err != ERR_NONE)),
        .pulse  (reconfig)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_fire) state_nx = (req_zero || req_rej) ? ST_RESP : ST_PUSH;
            ST_PUSH:  if (idx == r_last) state_nx = ST_START;
            ST_START: state_nx = ST_WAIT;
            ST_WAIT:  if (flags_any || tmo_hit) state_nx = ST_RESP;
            ST_RESP:  if (rsp_ready) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // request, frame and reply registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_native <= 1'b0;
            r_read   <= 1'b0;
            r_addr   <= '0;
            r_len    <= '0;
            idx      <= '0;
            r_last   <= '0;
            timer    <= '0;
            kind_q   <= RSP_ACK;
            err_q    <= ERR_NONE;
        end else begin
            unique case (state)
                ST_IDLE: if (req_fire) begin
                    r_native <= req_native;
                    r_read   <= req_read;
                    r_addr   <= req_addr;
                    r_len    <= req_len;
                    idx      <= '0;
                    r_last   <= req_read ? IDX_W'(3) : (len_x + IDX_W'(3));
                    kind_q   <= req_zero ? RSP_ACK : RSP_REJECT;
                    err_q    <= ERR_NONE;
                end
                ST_PUSH:  idx <= idx + IDX_W'(1);
                ST_START: timer <= '0;
                ST_WAIT: begin
                    if (flags_any) begin
                        err_q  <= map_err;
                        kind_q <= (map_err == ERR_NONE) ? RSP_ACK : RSP_DEFER;
                    end else if (tmo_hit) begin
                        err_q  <= ERR_TOUT;
                        kind_q <= RSP_DEFER;
                    end else begin
                        timer <= timer + TMO_W'(1);
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        busy       = (state != ST_IDLE);
        fifo_valid = (state == ST_PUSH);
        fifo_first = (state == ST_PUSH) && (idx == '0);
        go_valid   = (state == ST_START);
        go_i2c     = go_valid && !r_native;
        go_no_addr = go_valid && !r_native;
        go_no_stop = go_valid && !r_native && !r_read;
        rsp_valid  = (state == ST_RESP);
        rsp_kind   = kind_q;
        rsp_err    = err_q;
        rsp_i2c    = !r_native;
    end

endmodule

// File: rtl/aux_req_ctrl_chk.sv
module aux_req_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       busy,
    input logic       fifo_valid,
    input logic       go_valid,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [1:0] rsp_kind,
    input logic [2:0] rsp_err,
    input logic       rsp_i2c,
    input logic       reconfig
);

    // R5
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_valid |=> !go_valid && !fifo_valid);

    // R12
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy);

    // R12
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_err));

    // R8
    ack_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_kind == 2'd0) |-> (rsp_err == 3'd0));

    // R8
    defer_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_kind == 2'd1) |-> (rsp_err != 3'd0));

    // R11
    reconfig_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig |-> rsp_valid && (rsp_kind == 2'd1) && !rsp_i2c);

endmodule

bind aux_req_ctrl aux_req_ctrl_chk u_chk (.*);

// File: tb/sim_aux_req_ctrl.sv
module sim_aux_req_ctrl;

    localparam int TMO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_native = 1'b0, req_read = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0] req_len = '0;
    logic [7:0] pay_idx, pay_byte, fifo_byte;
    logic       req_ready, fifo_valid, fifo_first;
    logic       go_valid, go_i2c, go_no_addr, go_no_stop;
    logic [6:0] st_flags = '0;
    logic       rsp_valid, rsp_i2c, busy, reconfig;
    logic       rsp_ready = 1'b1;
    logic [1:0] rsp_kind;
    logic [2:0] rsp_err;

    int checks = 0, errors = 0;
    int nb, nfirst, nrc, ngo, mcnt = 0;
    bit first_at0;
    logic [7:0] fb [0:255];

    always #2.5 clk = ~clk;

    assign pay_byte = 8'(pay_idx * 37 + 11);

    aux_req_ctrl #(.TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_native(req_native), .req_read(req_read), .req_addr(req_addr),
        .req_len(req_len), .pay_idx(pay_idx), .pay_byte(pay_byte),
        .fifo_valid(fifo_valid), .fifo_first(fifo_first), .fifo_byte(fifo_byte),
        .go_valid(go_valid), .go_i2c(go_i2c), .go_no_addr(go_no_addr),
        .go_no_stop(go_no_stop), .st_flags(st_flags), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_i2c(rsp_i2c),
        .rsp_err(rsp_err), .busy(busy), .reconfig(reconfig)
    );

    always @(negedge clk) begin
        if (fifo_valid) begin
            if (nb < 256) fb[nb] = fifo_byte;
            if (fifo_first) begin
                nfirst++;
                if (nb == 0) first_at0 = 1'b1;
            end
            nb++;
        end
        if (reconfig) nrc++;
        if (go_valid) ngo++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] model_err(input bit nat, input logic [6:0] f);
        logic [2:0] e;
        e = 3'd0;
        if (nat) begin
            if (f[0]) e = 3'd0; else if (f[1]) e = 3'd1; else if (f[2]) e = 3'd2;
            if (f[3]) e = 3'd3;
            if (f[4]) e = 3'd6;
        end else if (f[0]) begin
            e = (f[5] || f[6]) ? 3'd3 : 3'd0;
        end else begin
            if (f[1]) e = 3'd1; else if (f[2]) e = 3'd2;
            if (f[3]) e = 3'd5;
            if (f[5]) e = 3'd3;
            if (f[6]) e = 3'd4;
            if (f[4]) e = 3'd6;
        end
        return e;
    endfunction

    task automatic xact(input bit nat, input bit rd, input logic [19:0] a,
                        input int len, input logic [6:0] fl, input bit tmo,
                        input bit hold);
        bit zero, rej;
        int w, exp_n, bad, exp_rc;
        logic [2:0] ee;
        logic [7:0] eb;
        zero = (len == 0);
        rej  = !zero && ((nat && len > 16) || len > 128 || (!rd && len + 4 > 128));
        nb = 0; nfirst = 0; nrc = 0; ngo = 0; first_at0 = 1'b0;
        req_native = nat; req_read = rd; req_addr = a; req_len = 8'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (zero || rej) begin
            chk(rsp_valid == 1'b1, zero ? "R4" : "R3", "reply at once", int'(rsp_valid), 1);
            chk(rsp_kind == (zero ? 2'd0 : 2'd2), zero ? "R4" : "R3", "kind",
                int'(rsp_kind), zero ? 0 : 2);
            chk(rsp_err == 3'd0 && rsp_i2c == !nat, zero ? "R4" : "R3", "err/i2c",
                int'({rsp_i2c, rsp_err}), int'({!nat, 3'd0}));
            @(negedge clk);
            chk(nb == 0 && ngo == 0, zero ? "R4" : "R3", "bytes+starts", nb + ngo, 0);
            chk(nrc == 0, "R11", "no reconfig on reject/empty", nrc, 0);
            return;
        end
        w = 0;
        while (!go_valid && w < 400) begin
            @(negedge clk);
            w++;
        end
        exp_n = rd ? 4 : len + 4;
        chk(go_valid == 1'b1 && w == exp_n, "R5", "start after last byte", w, exp_n);
        chk(go_i2c == !nat && go_no_addr == !nat && go_no_stop == (!nat && !rd), "R5",
            "start bits", int'({go_i2c, go_no_addr, go_no_stop}),
            int'({!nat, !nat, !nat && !rd}));
        chk(nb == exp_n, "R2", "fifo byte count", nb, exp_n);
        chk(nfirst == 1 && first_at0, "R1", "first marker", nfirst, 1);
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            eb = (i == 0) ? {3'b000, rd, a[19:16]} : (i == 1) ? a[15:8] :
                 (i == 2) ? a[7:0] : 8'(len - 1);
            if (fb[i] !== eb) bad++;
        end
        chk(bad == 0, "R1", "header mismatches", bad, 0);
        bad = 0;
        if (!rd) for (int k = 0; k < len; k++) if (fb[k + 4] !== 8'(k * 37 + 11)) bad++;
        chk(bad == 0, "R2", "payload mismatches", bad, 0);
        if (tmo) begin
            ee = 3'd2;
            w = 0;
            do begin
                @(negedge clk);
                w++;
            end while (!rsp_valid && w < TMO + 50);
            chk(w == TMO + 1, "R9", "timeout latency", w, TMO + 1);
        end else begin
            ee = model_err(nat, fl);
            @(negedge clk);
            st_flags = fl;
            @(negedge clk);
            st_flags = '0;
        end
        chk(rsp_valid == 1'b1, "R8", "reply valid", int'(rsp_valid), 1);
        chk(rsp_err == ee, nat ? "R6" : "R7", "error code", int'(rsp_err), int'(ee));
        chk(rsp_kind == ((ee == 3'd0) ? 2'd0 : 2'd1) && rsp_i2c == !nat, "R8",
            "kind/i2c", int'({rsp_i2c, rsp_kind}), int'({!nat, (ee == 3'd0) ? 2'd0 : 2'd1}));
        if (hold) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk(rsp_valid && busy && !req_ready && rsp_err == ee, "R12",
                    "reply held", int'({rsp_valid, busy, req_ready}), 6);
            end
            rsp_ready = 1'b1;
        end
        exp_rc = 0;
        if (ee == 3'd0) mcnt = 0;
        else if (nat) begin
            mcnt++;
            if (mcnt == 5) begin
                mcnt = 0;
                exp_rc = 1;
            end
        end
        @(negedge clk);
        chk(nrc == exp_rc, "R11", "reconfig pulses", nrc, exp_rc);
        chk(!busy && req_ready, "R12", "idle after reply", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy && !fifo_valid && !go_valid && !rsp_valid && !reconfig,
            "R12", "reset state", int'({req_ready, busy, fifo_valid, go_valid, rsp_valid}), 16);

        // R4 empty requests
        xact(1'b1, 1'b0, 20'h00100, 0, 7'h01, 1'b0, 1'b0);
        xact(1'b0, 1'b1, 20'h00050, 0, 7'h01, 1'b0, 1'b0);
        // R3 limits
        xact(1'b1, 1'b0, 20'h00200, 17, 7'h01, 1'b0, 1'b0);
        xact(1'b1, 1'b1, 20'h00200, 17, 7'h01, 1'b0, 1'b0);
        xact(1'b0, 1'b0, 20'h00050, 125, 7'h01, 1'b0, 1'b0);
        xact(1'b0, 1'b1, 20'h00050, 129, 7'h01, 1'b0, 1'b0);
        xact(1'b0, 1'b1, 20'h00050, 255, 7'h01, 1'b0, 1'b0);
        // R1 R2 R5 framing, accepted boundaries
        xact(1'b1, 1'b0, 20'hA5C3E, 1, 7'h01, 1'b0, 1'b0);
        xact(1'b1, 1'b0, 20'h3F00F, 16, 7'h01, 1'b0, 1'b0);
        xact(1'b1, 1'b1, 20'hFFFFF, 16, 7'h01, 1'b0, 1'b0);
        xact(1'b0, 1'b0, 20'h00050, 124, 7'h01, 1'b0, 1'b0);
        xact(1'b0, 1'b1, 20'h00050, 128, 7'h01, 1'b0, 1'b0);
        xact(1'b0, 1'b0, 20'h70030, 7, 7'h01, 1'b0, 1'b0);
        // R11 consecutive native failures
        for (int i = 0; i < 4; i++) xact(1'b1, 1'b1, 20'h00010, 2, 7'h02, 1'b0, 1'b0);
        xact(1'b1, 1'b1, 20'h00010, 2, 7'h01, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) xact(1'b1, 1'b1, 20'h00010, 2, 7'h04, 1'b0, 1'b0);
        xact(1'b0, 1'b1, 20'h00050, 2, 7'h10, 1'b0, 1'b0);
        xact(1'b1, 1'b1, 20'h00010, 2, 7'h08, 1'b0, 1'b0);
        // R9 completion timeout
        xact(1'b1, 1'b0, 20'h00020, 3, 7'h00, 1'b1, 1'b0);
        xact(1'b0, 1'b1, 20'h00050, 4, 7'h00, 1'b1, 1'b0);
        // R10 flags while idle
        st_flags = 7'h7F;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(!rsp_valid && req_ready && !busy, "R10", "idle flags ignored",
                int'({rsp_valid, req_ready}), 1);
        end
        st_flags = '0;
        @(negedge clk);
        xact(1'b1, 1'b1, 20'h00030, 1, 7'h01, 1'b0, 1'b0);
        // R12 reply backpressure
        rsp_ready = 1'b0;
        xact(1'b0, 1'b0, 20'h00050, 2, 7'h21, 1'b0, 1'b1);
        // R6 R7 sweep of every flag pattern
        for (int t = 0; t < 2; t++)
            for (int f = 1; f < 128; f++)
                xact(t[0], 1'b1, 20'(f * 4099), 1, 7'(f), 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not end actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule